// File: doc/BRIEF.md
# Block Exponent Assignment and Carry-Over Tap Rescaler

This block sits between the block formatter and the adaptive transversal filter of a block-floating-point signal path. At the first sample of every data block it receives the block's raw data exponent (one plus the floor of the base-2 logarithm of the largest magnitude over both the input and desired sequences of that block). From it, and from the raw exponent and common exponent it kept from the previous block, it chooses the block's scaling factor and common exponent. It holds both values, together with the signed exponent step from the previous block, for the whole block.

The filter's delay line reaches back into the previous block by `TAPS-1` samples. Those carried-over mantissas were formatted against the old exponent. The block shifts them once, at the block start, so that the whole delay line shares the new exponent. A second copy, shifted by a further `ceil(log2 TAPS)` places, is produced for the weight-update path. Between block starts every output holds.

Top module: `bexp_rescaler`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values after that edge: `scale_out` = Smin = ceil(log2 TAPS) (2 for the default of 4 taps), `blk_exp` = 0, `exp_step` = 0, both carry vectors all zero, and `carry_vld` = 0.
- R2: The first block start after reset gives `scale_out` = Smin, `blk_exp` = raw exponent + Smin and `exp_step` = 0.
- R3: At a later block start whose raw exponent is greater than or equal to the previous block's raw exponent, `scale_out` = Smin and `blk_exp` = raw exponent + Smin.
- R4: At a later block start whose raw exponent is below the previous block's raw exponent, `scale_out` = previous raw exponent − raw exponent + Smin and `blk_exp` = previous raw exponent + Smin. In both cases `blk_exp` − `scale_out` equals the raw exponent.
- R5: After a later block start, `exp_step` equals the new `blk_exp` minus the previous `blk_exp`, as a two's-complement number `EXP_W+1` bits wide.
- R6: `carry_filt` holds the carried-over taps captured at the block start, each shifted by `exp_step`. A positive step is an arithmetic right shift and a negative step is a left shift by its magnitude. Tap j (j = 0 for the most recent sample) sits in bits [j*MANT_W +: MANT_W], and each tap is a two's-complement mantissa.
- R7: `carry_upd` holds the same captured taps in the same layout, shifted by `exp_step` − Smin under the same sign rule.
- R8: All outputs change only at a clock edge where `blk_start` is high (or in reset), and become visible one cycle after it. `carry_vld` is high exactly in the cycle after each block start. Raw exponent and tap inputs have no effect while `blk_start` is low.
- R9: At every block start after the first, the previous `scale_out` plus the new `exp_step` is at least Smin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_start | input | 1 | High for one cycle at the first sample of a block |
| ex_raw | input | EXP_W | Signed raw data exponent of the new block |
| carry_in | input | (TAPS-1)*MANT_W | Carried-over delay-line mantissas, tap 0 in the low bits |
| scale_out | output | EXP_W+2 | Scaling factor of the current block (unsigned) |
| blk_exp | output | EXP_W+1 | Signed common exponent of the current block |
| exp_step | output | EXP_W+1 | Signed exponent step from the previous block |
| carry_filt | output | (TAPS-1)*MANT_W | Carried-over taps rescaled for the filter |
| carry_upd | output | (TAPS-1)*MANT_W | Carried-over taps rescaled with the extra Smin for weight update |
| carry_vld | output | 1 | High in the cycle after a block start |

## Verification
Assertions check several properties on every cycle. The exponent state holds between block starts, and the step equals the difference of consecutive common exponents. The common exponent minus the scaling factor reproduces the raw exponent, and the effective scaling of the carried taps never drops below Smin. The valid pulse follows each block start, and a zero step passes the taps through unchanged. The bench's block sequences alone can show the choice between the rising and falling raw-exponent cases, the exact shifted tap values (including shifts past the mantissa width), and the restart after a mid-stream reset. They also show that inputs changed between block starts do not disturb the outputs.

// File: rtl/bexp_pkg.sv
// Shared types of the block exponent assignment and rescaler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bexp_pkg;

    // Which rule picked the exponent of the block being started.
    typedef enum logic [1:0] {
        BLK_FIRST  = 2'd0,
        BLK_GROW   = 2'd1,
        BLK_SHRINK = 2'd2
    } blk_kind_e;

endpackage

// File: rtl/bexp_assign.sv
// Chooses the scaling factor and common exponent of each block from the
// raw exponent of the new block and the one kept from the previous block,
// and produces the signed exponent step. Values are registered at a block
// start and held until the next one.
// Assumes: SMIN is small enough that raw exponent + SMIN fits in GAM_W bits.
module bexp_assign
    import bexp_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int SMIN    = 2,
    parameter int GAM_W   = EXP_W + 1,
    parameter int DELTA_W = EXP_W + 1,
    parameter int S_W     = EXP_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      blk_start,
    input  logic signed [EXP_W-1:0]   ex_in,
    output logic [S_W-1:0]            s_out,
    output logic [GAM_W-1:0]          gam_out,
    output logic [DELTA_W-1:0]        delta_out,
    output logic [DELTA_W-1:0]        delta_nxt
);
    localparam int IW = EXP_W + 3;

    logic                     started_q;
    logic signed [EXP_W-1:0]  prev_ex_q;
    logic [GAM_W-1:0]         gam_q;
    logic [S_W-1:0]           s_q;
    logic [DELTA_W-1:0]       delta_q;

    logic signed [IW-1:0]     ex_w, prev_w, gam_w, smin_w;
    logic signed [IW-1:0]     gam_nxt_w, s_nxt_w, dlt_w;
    blk_kind_e                kind;

    // Widen the exponents and classify the block against the previous one.
    always_comb begin
        ex_w   = {{(IW-EXP_W){ex_in[EXP_W-1]}}, ex_in};
        prev_w = {{(IW-EXP_W){prev_ex_q[EXP_W-1]}}, prev_ex_q};
        gam_w  = {{(IW-GAM_W){gam_q[GAM_W-1]}}, gam_q};
        smin_w = IW'(SMIN);
        if (!started_q)
            kind = BLK_FIRST;
        else if (ex_w >= prev_w)
            kind = BLK_GROW;
        else
            kind = BLK_SHRINK;
    end

    // Pick exponent, scaling factor and step for the block being started.
    always_comb begin
        unique case (kind)
            BLK_SHRINK: begin
                gam_nxt_w = prev_w + smin_w;
                s_nxt_w   = prev_w - ex_w + smin_w;
            end
            default: begin
                gam_nxt_w = ex_w + smin_w;
                s_nxt_w   = smin_w;
            end
        endcase
        dlt_w = (kind == BLK_FIRST) ? '0 : (gam_nxt_w - gam_w);
    end

    // Capture the block's exponent state at its first sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            prev_ex_q <= '0;
            gam_q     <= '0;
            s_q       <= S_W'(SMIN);
            delta_q   <= '0;
        end else if (blk_start) begin
            started_q <= 1'b1;
            prev_ex_q <= ex_in;
            gam_q     <= gam_nxt_w[GAM_W-1:0];
            s_q       <= s_nxt_w[S_W-1:0];
            delta_q   <= dlt_w[DELTA_W-1:0];
        end
    end

    assign s_out     = s_q;
    assign gam_out   = gam_q;
    assign delta_out = delta_q;
    assign delta_nxt = dlt_w[DELTA_W-1:0];

    // Views used by the checks below.
    logic signed [IW-1:0] split_w;
    logic signed [IW-1:0] s_iw, d_iw;
    assign s_iw    = {{(IW-S_W){1'b0}}, s_q};
    assign d_iw    = {{(IW-DELTA_W){delta_q[DELTA_W-1]}}, delta_q};
    assign split_w = gam_w - s_iw;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> $stable(s_q) && $stable(gam_q) && $stable(delta_q));

    p_first_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start && !started_q |=> delta_q == '0);

    p_step_diff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start && started_q |=> delta_q == DELTA_W'(gam_q - $past(gam_q)));

    p_exp_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> split_w == $past(ex_w));

    p_eff_scale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start && started_q |=> ($past(s_iw) + d_iw) >= IW'(SMIN));

endmodule

// File: rtl/bexp_tap_shift.sv
// Captures the carried-over delay-line mantissas at a block start and
// shifts each by a signed amount: positive is an arithmetic right shift,
// negative a left shift by the magnitude. Holds between block starts.
// Assumes: amount magnitudes beyond the mantissa width flush to sign or zero.
module bexp_tap_shift #(
    parameter int MANT_W = 12,
    parameter int NCARRY = 3,
    parameter int AMT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic signed [AMT_W-1:0]   amt,
    input  logic [NCARRY*MANT_W-1:0]  taps_in,
    output logic [NCARRY*MANT_W-1:0]  taps_out
);
    logic [AMT_W-1:0]             mag;
    logic                         go_left;
    logic [NCARRY*MANT_W-1:0]     shifted;
    logic [NCARRY*MANT_W-1:0]     taps_q;

    // Split the signed amount into direction and magnitude.
    always_comb begin
        go_left = amt[AMT_W-1];
        mag     = go_left ? AMT_W'(-amt) : AMT_W'(amt);
    end

    for (genvar j = 0; j < NCARRY; j++) begin : g_tap
        logic signed [MANT_W-1:0] v;
        logic signed [MANT_W-1:0] r;
        assign v = taps_in[j*MANT_W +: MANT_W];
        // Shift one mantissa in the chosen direction.
        always_comb begin
            if (go_left)
                r = v << mag;
            else
                r = v >>> mag;
        end
        assign shifted[j*MANT_W +: MANT_W] = r;
    end

    // Register the rescaled taps only at a block start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            taps_q <= '0;
        else if (load)
            taps_q <= shifted;
    end

    assign taps_out = taps_q;

    p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(taps_q));

    p_zero_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load && amt == '0 |=> taps_q == $past(taps_in));

endmodule

// File: rtl/bexp_rescaler.sv
// Top of the block exponent assignment and carry-over tap rescaler.
// At each block start it picks the block's scaling factor and common
// exponent, and rescales the TAPS-1 carried-over taps twice: once for the
// filter and once with an extra SMIN for the weight-update path.
// Assumes: TAPS >= 2; blk_start is a single-cycle pulse per block.
module bexp_rescaler #(
    parameter int TAPS   = 4,
    parameter int MANT_W = 12,
    parameter int EXP_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             blk_start,
    input  logic signed [EXP_W-1:0]          ex_raw,
    input  logic [(TAPS-1)*MANT_W-1:0]       carry_in,
    output logic [EXP_W+1:0]                 scale_out,
    output logic [EXP_W:0]                   blk_exp,
    output logic [EXP_W:0]                   exp_step,
    output logic [(TAPS-1)*MANT_W-1:0]       carry_filt,
    output logic [(TAPS-1)*MANT_W-1:0]       carry_upd,
    output logic                             carry_vld
);
    localparam int SMIN    = $clog2(TAPS);
    localparam int NCARRY  = TAPS - 1;
    localparam int GAM_W   = EXP_W + 1;
    localparam int DELTA_W = EXP_W + 1;
    localparam int S_W     = EXP_W + 2;
    localparam int UAMT_W  = DELTA_W + 1;

    logic [DELTA_W-1:0]        delta_nxt;
    logic signed [UAMT_W-1:0]  upd_amt;
    logic                      vld_q;

    bexp_assign #(
        .EXP_W  (EXP_W),
        .SMIN   (SMIN),
        .GAM_W  (GAM_W),
        .DELTA_W(DELTA_W),
        .S_W    (S_W)
    ) i_assign (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_start(blk_start),
        .ex_in    (ex_raw),
        .s_out    (scale_out),
        .gam_out  (blk_exp),
        .delta_out(exp_step),
        .delta_nxt(delta_nxt)
    );

    // Weight-update copy uses the step reduced by SMIN.
    assign upd_amt = $signed({delta_nxt[DELTA_W-1], delta_nxt}) - UAMT_W'(SMIN);

    bexp_tap_shift #(
        .MANT_W(MANT_W),
        .NCARRY(NCARRY),
        .AMT_W (DELTA_W)
    ) i_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (blk_start),
        .amt     ($signed(delta_nxt)),
        .taps_in (carry_in),
        .taps_out(carry_filt)
    );

    bexp_tap_shift #(
        .MANT_W(MANT_W),
        .NCARRY(NCARRY),
        .AMT_W (UAMT_W)
    ) i_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (blk_start),
        .amt     (upd_amt),
        .taps_in (carry_in),
        .taps_out(carry_upd)
    );

    // Flag the cycle in which freshly rescaled taps are presented.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= 1'b0;
        else
            vld_q <= blk_start;
    end

    assign carry_vld = vld_q;

    p_vld_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> carry_vld);

    p_vld_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> !carry_vld);

endmodule

// File: tb/test_bexp_rescaler.sv
module test_bexp_rescaler;
    localparam int TAPS = 4, MANT_W = 12, EXP_W = 4;
    localparam int SMIN = 2, NC = TAPS - 1;
    localparam int GAM_W = EXP_W + 1, DELTA_W = EXP_W + 1, S_W = EXP_W + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_start = 1'b0;
    logic signed [EXP_W-1:0] ex_raw = '0;
    logic [NC*MANT_W-1:0] carry_in = '0;
    logic [S_W-1:0] scale_out;
    logic [GAM_W-1:0] blk_exp;
    logic [DELTA_W-1:0] exp_step;
    logic [NC*MANT_W-1:0] carry_filt, carry_upd;
    logic carry_vld;

    bexp_rescaler #(.TAPS(TAPS), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_bexp_rescaler (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .ex_raw(ex_raw),
        .carry_in(carry_in), .scale_out(scale_out), .blk_exp(blk_exp),
        .exp_step(exp_step), .carry_filt(carry_filt), .carry_upd(carry_upd),
        .carry_vld(carry_vld)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit chk_en = 0;

    // Behavioural reference state
    int m_started, m_prev_ex, m_gam, m_s, m_delta, m_vld;
    int m_filt[NC], m_upd[NC];
    string t_sg = "R1";

    function automatic int shref(int v, int a);
        if (a >= 0) return (a > 31) ? ((v < 0) ? -1 : 0) : (v >>> a);
        return (-a > 31) ? 0 : (v << (-a));
    endfunction

    task automatic chk(string tag, string what, int act, int expv, int w);
        int mask;
        mask = (w >= 32) ? -1 : ((1 << w) - 1);
        n_chk++;
        if (((act ^ expv) & mask) != 0) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act & mask, expv & mask);
        end
    endtask

    task automatic m_reset();
        m_started = 0; m_prev_ex = 0; m_gam = 0; m_s = SMIN; m_delta = 0; m_vld = 0;
        for (int j = 0; j < NC; j++) begin m_filt[j] = 0; m_upd[j] = 0; end
        t_sg = "R1";
    endtask

    task automatic m_apply(int ex, int t[NC]);
        int g, s, d;
        if (m_started == 0) begin
            g = ex + SMIN; s = SMIN; d = 0; t_sg = "R2";
        end else if (ex >= m_prev_ex) begin
            g = ex + SMIN; s = SMIN; d = g - m_gam; t_sg = "R3";
        end else begin
            g = m_prev_ex + SMIN; s = m_prev_ex - ex + SMIN; d = g - m_gam; t_sg = "R4";
        end
        for (int j = 0; j < NC; j++) begin
            m_filt[j] = shref(t[j], d);
            m_upd[j]  = shref(t[j], d - SMIN);
        end
        m_started = 1; m_prev_ex = ex; m_gam = g; m_s = s; m_delta = d;
    endtask

    // Compare every output with the reference once per clock, away from the edge.
    always @(negedge clk) begin
        if (chk_en) begin
            chk(t_sg, "scale", int'(scale_out), m_s, S_W);
            chk(t_sg, "exponent", int'(blk_exp), m_gam, GAM_W);
            chk((t_sg == "R1") ? "R1" : "R5", "step", int'(exp_step), m_delta, DELTA_W);
            for (int j = 0; j < NC; j++) begin
                chk("R6", "filter tap", int'(carry_filt[j*MANT_W +: MANT_W]), m_filt[j], MANT_W);
                chk("R7", "update tap", int'(carry_upd[j*MANT_W +: MANT_W]), m_upd[j], MANT_W);
            end
            chk("R8", "valid", int'(carry_vld), m_vld, 1);
        end
    end

    task automatic blk(int ex, int t0, int t1, int t2, int idle);
        int s_before, had_prev, eff;
        int t[NC];
        t[0] = t0; t[1] = t1; t[2] = t2;
        @(negedge clk);
        blk_start = 1'b1;
        ex_raw = ex[EXP_W-1:0];
        carry_in = {t2[MANT_W-1:0], t1[MANT_W-1:0], t0[MANT_W-1:0]};
        s_before = int'(scale_out);
        had_prev = m_started;
        @(posedge clk); #1;
        m_apply(ex, t);
        m_vld = 1;
        @(negedge clk);
        if (had_prev != 0) begin
            eff = s_before + int'($signed(exp_step));
            chk("R9", "effective scale >= Smin", int'(eff >= SMIN), 1, 1);
        end
        // Disturb the inputs while blk_start is low: outputs must hold (R8).
        blk_start = 1'b0;
        ex_raw = ~ex_raw;
        carry_in = ~carry_in;
        @(posedge clk); #1;
        m_vld = 0;
        repeat (idle) @(posedge clk);
    endtask

    initial begin
        m_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk_en = 1;
        @(negedge clk);
        // R1: reset values
        chk("R1", "reset scale", int'(scale_out), SMIN, S_W);
        chk("R1", "reset exponent", int'(blk_exp), 0, GAM_W);
        chk("R1", "reset taps", int'(carry_filt != '0 || carry_upd != '0), 0, 1);
        rst_n = 1'b1;

        blk(1, 100, -200, 300, 2);    // R2: first block
        blk(3, 100, -200, 300, 2);    // R3: rise, step +2
        blk(0, -77, 55, 1000, 1);     // R4: fall, scale 5, step 0
        blk(-2, 5, -3, 17, 1);        // R4: fall, step -3 (left shift)
        blk(-1, 40, -41, 9, 1);       // R3: rise but exponent drops, step -1
        blk(7, 2047, -2048, 1, 1);    // R3: big rise, step +8
        blk(-8, -1, 1, 513, 1);       // R4: scale 17
        blk(-8, 3, -3, 64, 1);        // R3: equal, step -15 flushes taps
        blk(-8, 12, -12, 6, 2);       // R3: equal, step 0

        // Mid-stream reset, then a fresh first block (R1, R2).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        blk(-3, -600, 600, 7, 1);     // R2 again
        blk(5, 1024, -1024, 256, 1);  // R3
        blk(2, 33, -34, 35, 3);       // R4

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule